// File: doc/BRIEF.md
# Banked Logical-to-Physical Address Translator

This block sits between a CPU with a 16-bit logical address bus and a 20-bit physical memory. It sorts every logical address into one of three areas, using the 4K page number in the top four address bits. The lowest area, called root, passes through with its upper physical bits set to zero. The middle area, called bank, is moved by an 8-bit bank base. The top area, called common, is moved by an 8-bit common base. Each base counts in 4K steps.

Two page limits, packed into one 8-bit limit register, set where the areas start. The translation is combinational. It gives the physical address and an area code in the same cycle as the logical address. Three 8-bit registers hold the setup. The CPU loads them through a small write port: a strobe, a 2-bit select and a data byte. A loaded value governs translation from the next clock cycle on.

Top module: `bank_mmu`

## Requirements
- R1: After reset the limit register holds 0xF0 and both bases hold 0x00, so the physical address equals the logical address with four zero bits added on top.
- R2: When the logical page (address bits [15:12]) is greater than or equal to the common start page (limit bits [7:4]), the area output is 2.
- R3: When the logical page is at or above the bank start page (limit bits [3:0]) and below the common start page, the area output is 1.
- R4: When the logical page is below both start pages, the area output is 0 and the physical address equals the logical address with zero upper bits.
- R5: In the common area the physical address is the common base times 0x1000 plus the logical address.
- R6: In the bank area the physical address is the bank base times 0x1000 plus the logical address.
- R7: When the common start page is less than or equal to the bank start page, no address is placed in the bank area. Pages at or above the common start go to the common area and all other pages go to the root area.
- R8: A write with select 0 loads the limit register, select 1 loads the common base and select 2 loads the bank base. A write with select 3 changes no register.
- R9: A write changes nothing in the cycle in which the strobe is high. The new value applies to translations from the next clock edge on.
- R10: The relocation sum is cut to 20 bits, so a translation that passes 0xFFFFF wraps around to the bottom of physical memory.
- R11: While the write strobe is low, all three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| log_addr | input | 16 | Logical address from the CPU |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 limit, 1 common base, 2 bank base, 3 none |
| cfg_data | input | 8 | Register write data |
| phys_addr | output | 20 | Translated physical address |
| area | output | 2 | Area code: 0 root, 1 bank, 2 common |

## Verification
Any wrong register value shows up at the ports in the first cycle in which a logical address falls in the area that register governs. A corrupted limit moves the area code at a page edge. A corrupted base shifts the physical address by a whole number of 4K pages. The bench changes the address on every cycle and compares against its own model on every cycle, so a stray or missing write shows up within a few cycles of its effect. Writes on the ignored select and same-cycle reads are checked directly, because a wrong write timing would only show up as a one-cycle mismatch.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int MMU_REG_W  = 8;
    localparam int MMU_PAGE_W = MMU_REG_W / 2;

    typedef enum logic [1:0] {
        AREA_ROOT   = 2'd0,
        AREA_BANK   = 2'd1,
        AREA_COMMON = 2'd2
    } mmu_area_e;

    typedef enum logic [1:0] {
        SEL_LIMIT = 2'd0,
        SEL_CBASE = 2'd1,
        SEL_BBASE = 2'd2,
        SEL_NONE  = 2'd3
    } mmu_sel_e;

    typedef struct packed {
        logic [MMU_REG_W-1:0] limit;
        logic [MMU_REG_W-1:0] cbase;
        logic [MMU_REG_W-1:0] bbase;
    } mmu_regs_t;

endpackage

// File: rtl/mmu_regfile.sv
module mmu_regfile
    import mmu_pkg::*;
#(
    parameter logic [MMU_REG_W-1:0] RST_LIMIT = 8'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [MMU_REG_W-1:0] wr_data,
    output mmu_regs_t            regs_q
);

    mmu_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (mmu_sel_e'(wr_sel))
                SEL_LIMIT: regs_d.limit = wr_data;
                SEL_CBASE: regs_d.cbase = wr_data;
                SEL_BBASE: regs_d.bbase = wr_data;
                default:   regs_d       = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.limit <= RST_LIMIT;
            regs_q.cbase <= '0;
            regs_q.bbase <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/mmu_area_decode.sv
module mmu_area_decode
    import mmu_pkg::*;
#(
    parameter int LA_W = 16
) (
    input  logic [LA_W-1:0]      log_addr,
    input  logic [MMU_REG_W-1:0] limit,
    output mmu_area_e            area
);

    logic [MMU_PAGE_W-1:0] page;
    logic [MMU_PAGE_W-1:0] com_start;
    logic [MMU_PAGE_W-1:0] bank_start;
    logic                  in_common;
    logic                  in_bank;

    always_comb begin
        page       = log_addr[LA_W-1 -: MMU_PAGE_W];
        com_start  = limit[MMU_REG_W-1 -: MMU_PAGE_W];
        bank_start = limit[MMU_PAGE_W-1:0];
        in_common  = (page >= com_start);
        in_bank    = (page >= bank_start);
        if (in_common)    area = AREA_COMMON;
        else if (in_bank) area = AREA_BANK;
        else              area = AREA_ROOT;
    end

endmodule

// File: rtl/mmu_relocate.sv
module mmu_relocate #(
    parameter int LA_W   = 16,
    parameter int PA_W   = 20,
    parameter int BASE_W = 8,
    parameter int SHIFT  = 12
) (
    input  logic [LA_W-1:0]   log_addr,
    input  logic [BASE_W-1:0] base,
    output logic [PA_W-1:0]   phys_addr
);

    logic [PA_W-1:0] base_ext;
    logic [PA_W-1:0] addr_ext;

    always_comb begin
        base_ext  = PA_W'(base) << SHIFT;
        addr_ext  = PA_W'(log_addr);
        phys_addr = base_ext + addr_ext;
    end

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
    import mmu_pkg::*;
#(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LA_W-1:0]      log_addr,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_sel,
    input  logic [MMU_REG_W-1:0] cfg_data,
    output logic [PA_W-1:0]      phys_addr,
    output logic [1:0]           area
);

    localparam int SHIFT   = LA_W - MMU_PAGE_W;
    localparam int N_RELOC = 2;

    mmu_regs_t        regs_q;
    mmu_area_e        area_sel;
    logic [MMU_REG_W-1:0] reloc_base [N_RELOC];
    logic [PA_W-1:0]  reloc_addr [N_RELOC];

    mmu_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .regs_q  (regs_q)
    );

    mmu_area_decode #(.LA_W(LA_W)) u_decode (
        .log_addr (log_addr),
        .limit    (regs_q.limit),
        .area     (area_sel)
    );

    assign reloc_base[0] = regs_q.bbase;
    assign reloc_base[1] = regs_q.cbase;

    for (genvar k = 0; k < N_RELOC; k++) begin : g_reloc
        mmu_relocate #(
            .LA_W   (LA_W),
            .PA_W   (PA_W),
            .BASE_W (MMU_REG_W),
            .SHIFT  (SHIFT)
        ) u_reloc (
            .log_addr  (log_addr),
            .base      (reloc_base[k]),
            .phys_addr (reloc_addr[k])
        );
    end

    always_comb begin
        case (area_sel)
            AREA_BANK:   phys_addr = reloc_addr[0];
            AREA_COMMON: phys_addr = reloc_addr[1];
            default:     phys_addr = PA_W'(log_addr);
        endcase
        area = area_sel;
    end

endmodule

// File: rtl/mmu_checker.sv
module mmu_checker
    import mmu_pkg::*;
#(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LA_W-1:0]      log_addr,
    input logic                 cfg_wr,
    input logic [1:0]           cfg_sel,
    input logic [MMU_REG_W-1:0] cfg_data,
    input logic [PA_W-1:0]      phys_addr,
    input logic [1:0]           area,
    input mmu_regs_t            regs
);

    logic [MMU_PAGE_W-1:0] pg;
    logic [MMU_PAGE_W-1:0] cs;
    logic [MMU_PAGE_W-1:0] bs;
    assign pg = log_addr[LA_W-1 -: MMU_PAGE_W];
    assign cs = regs.limit[MMU_REG_W-1 -: MMU_PAGE_W];
    assign bs = regs.limit[MMU_PAGE_W-1:0];

    assert_root_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        area == 2'd0 |-> phys_addr == PA_W'(log_addr));

    assert_area_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        area != 2'd3);

    assert_common_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        area == 2'd2 |-> pg >= cs);

    assert_bank_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        area == 2'd1 |-> (pg >= bs) && (pg < cs));

    assert_empty_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs <= bs |-> area != 2'd1);

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == 2'd1 |=> regs.cbase == $past(cfg_data));

    assert_ignored_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == 2'd3 |=> $stable(regs));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(regs));

endmodule

bind bank_mmu mmu_checker #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_addr  (log_addr),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .phys_addr (phys_addr),
    .area      (area),
    .regs      (regs_q)
);

// File: tb/bank_mmu_bench.sv
module bank_mmu_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] log_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic [19:0] phys_addr;
    logic [1:0]  area;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural model state
    int m_limit = 'hF0;
    int m_cb = 0;
    int m_bb = 0;

    always #(PERIOD/2) clk = ~clk;

    bank_mmu u_bank_mmu (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_addr  (log_addr),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .phys_addr (phys_addr),
        .area      (area)
    );

    function automatic void model(input int la, output int exp_pa, output int exp_ar);
        int pg, cs, bs;
        pg = la / 4096;
        cs = m_limit / 16;
        bs = m_limit % 16;
        if (pg >= cs) begin
            exp_ar = 2; exp_pa = (m_cb * 4096 + la) % 1048576;
        end else if (pg >= bs) begin
            exp_ar = 1; exp_pa = (m_bb * 4096 + la) % 1048576;
        end else begin
            exp_ar = 0; exp_pa = la;
        end
    endfunction

    // one cycle: drive, check before the edge, then apply the write to the model
    task automatic step(input string tag, input int la, input bit wr, input int sel, input int data);
        int ep, ea;
        @(negedge clk);
        log_addr = la[15:0];
        cfg_wr   = wr;
        cfg_sel  = sel[1:0];
        cfg_data = data[7:0];
        #(PERIOD/4);
        model(la, ep, ea);
        tests++;
        if (int'(phys_addr) != ep || int'(area) != ea) begin
            fails++;
            $display("FAIL %s la=%h: pa=%h area=%0d expected pa=%h area=%0d",
                     tag, la, phys_addr, area, ep, ea);
        end
        @(posedge clk);
        if (wr) begin
            case (sel)
                0: m_limit = data & 255;
                1: m_cb = data & 255;
                2: m_bb = data & 255;
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset identity at several addresses
        step("R1", 'h0000, 0, 0, 0);
        step("R1", 'h7ABC, 0, 0, 0);
        step("R1", 'hFFFF, 0, 0, 0);
        // R8, R9: program limit 0xE2; same-cycle output still uses old limit
        step("R9", 'h1000, 1, 0, 'hE2);
        step("R4", 'h1234, 0, 0, 0);
        step("R4", 'h0000, 0, 0, 0);
        step("R9", 'h3000, 1, 2, 'h40);
        step("R6", 'h3456, 0, 0, 0);
        step("R3", 'hDFFF, 0, 0, 0);
        step("R3", 'h2000, 1, 1, 'h10);
        step("R5", 'hE000, 0, 0, 0);
        step("R2", 'hF00F, 0, 0, 0);
        // R10: wrap modulo 1M
        step("R10", 'hFFFF, 1, 1, 'hFF);
        step("R10", 'hFFFF, 1, 2, 'hFF);
        step("R10", 'hD123, 0, 0, 0);
        // R8: select 3 is ignored
        step("R8", 'hE000, 1, 3, 'h00);
        step("R8", 'hE000, 0, 0, 0);
        step("R8", 'h3000, 0, 0, 0);
        step("R8", 'h1000, 0, 0, 0);
        // R7: empty bank when common start <= bank start
        step("R7", 'h0000, 1, 0, 'h35);
        step("R7", 'h4000, 0, 0, 0);
        step("R7", 'h2FFF, 0, 0, 0);
        step("R7", 'h3000, 0, 0, 0);
        step("R7", 'h5000, 1, 0, 'h55);
        step("R7", 'h4FFF, 0, 0, 0);
        step("R7", 'h5000, 0, 0, 0);
        // R11: idle cycles hold state
        for (int i = 0; i < 16; i++) step("R11", i * 4099 % 65536, 0, 0, 0);
        // random traffic compared every clock
        for (int i = 0; i < 3000; i++) begin
            int la, sel, dat;
            bit wr;
            la  = $urandom_range(0, 65535);
            wr  = ($urandom_range(0, 3) == 0);
            sel = $urandom_range(0, 3);
            dat = $urandom_range(0, 255);
            step("RND", la, wr, sel, dat);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                fails++;
                tests++;
                $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

endmodule